// File: doc/BRIEF.md
# Duplicate Track Filter

This block sits after a track fitter and removes tracks that describe the same particle. Fitted tracks come in as a group, one per cycle. Each track carries a road number, a hit identifier and a presence bit for every detector layer, a hit count and a fit quality value, where a lower chi-square is better. Every incoming track is compared in one cycle against all tracks retained so far in the group. If it shares more hits than a programmable limit with a retained track, only the better of the two is kept.

A mode input selects the comparison scope. In per-road scope, only tracks carrying the same road number are compared. In whole-event scope, every pair of tracks is compared. The final track of a group is flagged on the input. When the flagged track has been processed, the block drains its retained set on the output, one track per cycle, and then marks the end of the group. The retained set has a fixed depth. A track that finds the set full and has no duplicate is forwarded at once without checks, and a sticky error flag is set.

Top module: `dup_filter`

## Requirements
- R1: A hit is shared between two tracks only in a layer where both presence bits are 1 and both hit identifiers are equal. A layer whose presence bit is 0 in either track never counts as shared. Layer l occupies bits [l*HID_W +: HID_W] of the hit field and bit l of the presence mask.
- R2: Two tracks are duplicates when their shared-hit count is strictly greater than `nmax`. A count equal to `nmax` does not make them duplicates.
- R3: Of a duplicate pair, the track with the larger hit count survives.
- R4: When the hit counts are equal, the track with the lower chi-square survives. When both the hit counts and the chi-square values are equal, the retained track survives and the new track is discarded.
- R5: When `mode_all` is 0, only tracks with equal road numbers are compared. When `mode_all` is 1, tracks are compared regardless of road.
- R6: A new track that beats every retained duplicate takes the buffer slot of the lowest-numbered of those duplicates. All the other duplicates are removed. Later non-duplicate tracks go to fresh slots after the highest slot used so far.
- R7: In the cycle after the track flagged by `in_last` is accepted, draining starts. Survivors appear on `out_valid` in slot order, which is the order in which slots were first filled. Then `out_last` is high for one cycle with `out_valid` low, and the retained set is empty again.
- R8: `in_ready` is low from the cycle after the flagged track is accepted. It is high again in the cycle in which `out_last` is high. Tracks are accepted only while `in_ready` is high.
- R9: A track that finds all DEPTH slots filled and has no duplicate appears on the output in the next cycle. `ovf_err` rises in that same cycle and stays high until reset.
- R10: After reset, `in_ready` is 1 and `out_valid`, `out_last` and `ovf_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_all | input | 1 | 1: compare all tracks; 0: compare only tracks with the same road |
| nmax | input | $clog2(NL+1) | Shared-hit limit |
| in_valid | input | 1 | Input track present |
| in_last | input | 1 | Input track is the last of its group |
| in_road | input | ROAD_W | Road number |
| in_hid | input | NL*HID_W | Hit identifier for each layer |
| in_hmask | input | NL | Hit presence for each layer |
| in_nhit | input | $clog2(NL+1) | Hit count |
| in_chi | input | CHI_W | Fit chi-square |
| in_ready | output | 1 | Block can accept a track |
| out_valid | output | 1 | Output track present |
| out_last | output | 1 | End of the output group |
| out_road | output | ROAD_W | Road number |
| out_hid | output | NL*HID_W | Hit identifiers |
| out_hmask | output | NL | Hit presence |
| out_nhit | output | $clog2(NL+1) | Hit count |
| out_chi | output | CHI_W | Chi-square |
| ovf_err | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with DEPTH=4, NL=4 and HID_W=6, so five distinct tracks in one group are enough to fill the set and exercise the overflow pass-through and the sticky flag. With four layers, a shared-hit limit of 2 or 0 is easy to sit just under and just over, and presence masks can separate layers that carry equal identifiers. The small depth also lets a single group show a new track that wins over two retained duplicates, the hole left in the slots, and a later track landing after that hole.

// File: rtl/dup_pkg.sv
package dup_pkg;
  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_DRAIN   = 1'b1
  } dup_state_e;
endpackage

// File: rtl/dup_share.sv
// Counts layers where both tracks carry a hit with the same identifier.
module dup_share #(
  parameter int NL    = 8,
  parameter int HID_W = 8,
  parameter int CNT_W = 4
) (
  input  logic [NL*HID_W-1:0] a_hid,
  input  logic [NL*HID_W-1:0] b_hid,
  input  logic [NL-1:0]       a_mask,
  input  logic [NL-1:0]       b_mask,
  output logic [CNT_W-1:0]    cnt
);
  logic [NL-1:0] same;

  for (genvar l = 0; l < NL; l++) begin : g_layer
    assign same[l] = a_mask[l] & b_mask[l] &
                     (a_hid[l*HID_W +: HID_W] == b_hid[l*HID_W +: HID_W]);
  end

  always_comb begin
    cnt = '0;
    for (int l = 0; l < NL; l++) cnt = cnt + CNT_W'(same[l]);
  end
endmodule

// File: rtl/dup_cmp.sv
// Compares the incoming track with one retained slot.
module dup_cmp #(
  parameter int NL     = 8,
  parameter int HID_W  = 8,
  parameter int ROAD_W = 8,
  parameter int CHI_W  = 12,
  parameter int CNT_W  = 4
) (
  input  logic                mode_all,
  input  logic [CNT_W-1:0]    nmax,
  input  logic                slot_vld,
  input  logic [ROAD_W-1:0]   a_road,
  input  logic [NL*HID_W-1:0] a_hid,
  input  logic [NL-1:0]       a_mask,
  input  logic [CNT_W-1:0]    a_nhit,
  input  logic [CHI_W-1:0]    a_chi,
  input  logic [ROAD_W-1:0]   b_road,
  input  logic [NL*HID_W-1:0] b_hid,
  input  logic [NL-1:0]       b_mask,
  input  logic [CNT_W-1:0]    b_nhit,
  input  logic [CHI_W-1:0]    b_chi,
  output logic                is_dup,
  output logic                new_better
);
  logic [CNT_W-1:0] shared;

  dup_share #(.NL(NL), .HID_W(HID_W), .CNT_W(CNT_W)) u_share (
    .a_hid(a_hid), .b_hid(b_hid), .a_mask(a_mask), .b_mask(b_mask), .cnt(shared)
  );

  assign is_dup     = slot_vld & (mode_all | (a_road == b_road)) & (shared > nmax);
  assign new_better = (a_nhit > b_nhit) | ((a_nhit == b_nhit) & (a_chi < b_chi));
endmodule

// File: rtl/dup_first.sv
// Lowest set index of a vector.
module dup_first #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) if (vec[i]) idx = IW'(i);
  end
  assign any = |vec;
endmodule

// File: rtl/dup_filter.sv
module dup_filter #(
  parameter int NL     = 8,
  parameter int HID_W  = 8,
  parameter int ROAD_W = 8,
  parameter int CHI_W  = 12,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(NL + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mode_all,
  input  logic [CNT_W-1:0]    nmax,
  input  logic                in_valid,
  input  logic                in_last,
  input  logic [ROAD_W-1:0]   in_road,
  input  logic [NL*HID_W-1:0] in_hid,
  input  logic [NL-1:0]       in_hmask,
  input  logic [CNT_W-1:0]    in_nhit,
  input  logic [CHI_W-1:0]    in_chi,
  output logic                in_ready,
  output logic                out_valid,
  output logic                out_last,
  output logic [ROAD_W-1:0]   out_road,
  output logic [NL*HID_W-1:0] out_hid,
  output logic [NL-1:0]       out_hmask,
  output logic [CNT_W-1:0]    out_nhit,
  output logic [CHI_W-1:0]    out_chi,
  output logic                ovf_err
);
  import dup_pkg::*;

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PTR_W = $clog2(DEPTH + 1);

  dup_state_e state;
  logic [PTR_W-1:0] wptr, rd;
  logic [DEPTH-1:0] s_vld, s_vld_nxt;

  logic [ROAD_W-1:0]   s_road [DEPTH];
  logic [NL*HID_W-1:0] s_hid  [DEPTH];
  logic [NL-1:0]       s_mask [DEPTH];
  logic [CNT_W-1:0]    s_nhit [DEPTH];
  logic [CHI_W-1:0]    s_chi  [DEPTH];

  logic [DEPTH-1:0] dup_vec, win_vec;
  logic [IDX_W-1:0] first_idx, wr_idx, rd_i;
  logic any_dup, lose, full, in_fire;
  logic do_alloc, do_replace, do_pass, wr_en, drain_emit;

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    dup_cmp #(.NL(NL), .HID_W(HID_W), .ROAD_W(ROAD_W), .CHI_W(CHI_W), .CNT_W(CNT_W)) u_cmp (
      .mode_all(mode_all), .nmax(nmax), .slot_vld(s_vld[j]),
      .a_road(in_road), .a_hid(in_hid), .a_mask(in_hmask), .a_nhit(in_nhit), .a_chi(in_chi),
      .b_road(s_road[j]), .b_hid(s_hid[j]), .b_mask(s_mask[j]), .b_nhit(s_nhit[j]),
      .b_chi(s_chi[j]), .is_dup(dup_vec[j]), .new_better(win_vec[j])
    );
  end

  dup_first #(.N(DEPTH), .IW(IDX_W)) u_first (.vec(dup_vec), .idx(first_idx), .any(any_dup));

  assign in_ready   = (state == ST_COLLECT);
  assign in_fire    = in_valid & in_ready;
  assign lose       = |(dup_vec & ~win_vec);
  assign full       = (wptr == PTR_W'(DEPTH));
  assign do_alloc   = in_fire & ~any_dup & ~full;
  assign do_replace = in_fire & any_dup & ~lose;
  assign do_pass    = in_fire & ~any_dup & full;
  assign wr_en      = do_alloc | do_replace;
  assign wr_idx     = do_alloc ? wptr[IDX_W-1:0] : first_idx;
  assign rd_i       = rd[IDX_W-1:0];
  assign drain_emit = (state == ST_DRAIN) && (rd < wptr);

  always_comb begin
    s_vld_nxt = s_vld;
    if (do_alloc)   s_vld_nxt[wr_idx] = 1'b1;
    if (do_replace) s_vld_nxt = (s_vld & ~dup_vec) | (DEPTH'(1) << first_idx);
  end

  // Slot storage: single write port, no reset, one registered read.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      s_road[wr_idx] <= in_road;
      s_hid[wr_idx]  <= in_hid;
      s_mask[wr_idx] <= in_hmask;
      s_nhit[wr_idx] <= in_nhit;
      s_chi[wr_idx]  <= in_chi;
    end
  end

  always_ff @(posedge clk) begin
    if (do_pass) begin
      out_road <= in_road; out_hid <= in_hid; out_hmask <= in_hmask;
      out_nhit <= in_nhit; out_chi <= in_chi;
    end else if (drain_emit) begin
      out_road <= s_road[rd_i]; out_hid <= s_hid[rd_i]; out_hmask <= s_mask[rd_i];
      out_nhit <= s_nhit[rd_i]; out_chi <= s_chi[rd_i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_COLLECT; wptr <= '0; rd <= '0; s_vld <= '0;
      out_valid <= 1'b0; out_last <= 1'b0; ovf_err <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if (state == ST_COLLECT) begin
        s_vld <= s_vld_nxt;
        if (do_alloc) wptr <= wptr + PTR_W'(1);
        if (do_pass) begin
          out_valid <= 1'b1;
          ovf_err   <= 1'b1;
        end
        if (in_fire && in_last) begin
          state <= ST_DRAIN;
          rd    <= '0;
        end
      end else if (drain_emit) begin
        out_valid <= s_vld[rd_i];
        rd        <= rd + PTR_W'(1);
      end else begin
        out_last <= 1'b1;
        state    <= ST_COLLECT;
        wptr     <= '0;
        s_vld    <= '0;
      end
    end
  end

  a_r9_sticky: assert property (@(posedge clk) disable iff (rst) ovf_err |=> ovf_err);
  a_r9_pass: assert property (@(posedge clk) disable iff (rst) do_pass |=> out_valid && ovf_err);
  a_r9_bound: assert property (@(posedge clk) disable iff (rst) wptr <= PTR_W'(DEPTH));
  a_r8_block: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> !in_ready);
  a_r4_drop: assert property (@(posedge clk) disable iff (rst)
    (in_fire && any_dup && lose) |=> $stable(s_vld) && $stable(wptr));
  a_r6_take: assert property (@(posedge clk) disable iff (rst)
    do_replace |=> s_vld[$past(first_idx)]);
endmodule

// File: tb/test_dup_filter.sv
module test_dup_filter;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4, HID_W = 6, ROAD_W = 8, CHI_W = 8, DEPTH = 4;
  localparam int CNT_W = $clog2(NL + 1);

  typedef struct packed {
    logic [ROAD_W-1:0]   road;
    logic [NL-1:0]       mask;
    logic [NL*HID_W-1:0] hid;
    logic [CNT_W-1:0]    nhit;
    logic [CHI_W-1:0]    chi;
  } trk_t;

  logic clk = 1'b0, rst = 1'b1, mode_all = 1'b0, in_valid = 1'b0, in_last = 1'b0;
  logic [CNT_W-1:0] nmax = 3'd2;
  trk_t din = '0;
  logic in_ready, out_valid, out_last, ovf_err;
  logic [ROAD_W-1:0] out_road;
  logic [NL*HID_W-1:0] out_hid;
  logic [NL-1:0] out_hmask;
  logic [CNT_W-1:0] out_nhit;
  logic [CHI_W-1:0] out_chi;

  int total = 0, bad = 0;
  trk_t got[$], exp_q[$];
  bit eog;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dup_filter #(.NL(NL), .HID_W(HID_W), .ROAD_W(ROAD_W), .CHI_W(CHI_W), .DEPTH(DEPTH)) i_dup_filter (
    .clk(clk), .rst(rst), .mode_all(mode_all), .nmax(nmax), .in_valid(in_valid),
    .in_last(in_last), .in_road(din.road), .in_hid(din.hid), .in_hmask(din.mask),
    .in_nhit(din.nhit), .in_chi(din.chi), .in_ready(in_ready), .out_valid(out_valid),
    .out_last(out_last), .out_road(out_road), .out_hid(out_hid), .out_hmask(out_hmask),
    .out_nhit(out_nhit), .out_chi(out_chi), .ovf_err(ovf_err)
  );

  function automatic trk_t mk(int road, int h0, int h1, int h2, int h3, int mask, int nhit, int chi);
    trk_t t;
    t.road = ROAD_W'(road);
    t.hid  = {HID_W'(h3), HID_W'(h2), HID_W'(h1), HID_W'(h0)};
    t.mask = NL'(mask);
    t.nhit = CNT_W'(nhit);
    t.chi  = CHI_W'(chi);
    return t;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic step();
    trk_t r;
    @(negedge clk);
    if (out_valid) begin
      r.road = out_road; r.hid = out_hid; r.mask = out_hmask; r.nhit = out_nhit; r.chi = out_chi;
      got.push_back(r);
    end
    if (out_last) eog = 1'b1;
  endtask

  task automatic send(trk_t t, bit last);
    din = t; in_valid = 1'b1; in_last = last;
    step();
  endtask

  task automatic end_grp(string req);
    in_valid = 1'b0; in_last = 1'b0;
    chk(in_ready == 1'b0, "R8 ready low while draining", 64'(in_ready), 64'd0);
    for (int i = 0; i < 40 && !eog; i++) step();
    chk(eog, "R7 end-of-group marker seen", 64'(eog), 64'd1);
    chk(in_ready == 1'b1, "R8 ready back with out_last", 64'(in_ready), 64'd1);
    chk(got.size() == exp_q.size(), {req, " survivor count"}, 64'(got.size()), 64'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got.size(); i++)
      chk(got[i] == exp_q[i], {req, " survivor content"}, 64'(got[i]), 64'(exp_q[i]));
    got.delete(); exp_q.delete(); eog = 1'b0;
  endtask

  // R7: distinct tracks all survive in arrival order
  task automatic t_order();
    trk_t a = mk(1, 1, 2, 3, 4, 15, 4, 10), b = mk(1, 5, 6, 7, 8, 15, 4, 20), c = mk(1, 9, 10, 11, 12, 15, 4, 5);
    nmax = 3'd2; mode_all = 1'b0;
    send(a, 0); send(b, 0); send(c, 1);
    exp_q = '{a, b, c};
    end_grp("R7 order");
  endtask

  // R2: exactly nmax shared keeps both, nmax+1 shared is a duplicate (tie keeps retained, R4)
  task automatic t_thresh();
    trk_t a = mk(1, 1, 2, 3, 4, 15, 4, 10), b = mk(1, 1, 2, 9, 9, 15, 4, 10), c = mk(1, 1, 2, 3, 9, 15, 4, 10);
    send(a, 0); send(b, 0); send(c, 1);
    exp_q = '{a, b};
    end_grp("R2 threshold");
  endtask

  // R3: more hits wins in both directions
  task automatic t_hits();
    trk_t a = mk(1, 1, 2, 3, 0, 7, 3, 5), b = mk(1, 1, 2, 3, 4, 15, 4, 50);
    trk_t c = mk(1, 30, 31, 32, 33, 15, 4, 9), d = mk(1, 20, 21, 22, 23, 15, 4, 50);
    trk_t e = mk(1, 20, 21, 22, 0, 7, 3, 1);
    send(a, 0); send(b, 0); send(c, 0); send(d, 0); send(e, 1);
    exp_q = '{b, c, d};
    end_grp("R3 hit count");
  endtask

  // R4: equal hits, lower chi wins; equal chi keeps retained
  task automatic t_chi();
    trk_t a = mk(1, 1, 2, 3, 4, 15, 4, 30), b = mk(1, 1, 2, 3, 4, 15, 4, 20);
    trk_t c = mk(1, 1, 2, 3, 4, 15, 4, 20), d = mk(1, 1, 2, 3, 4, 15, 4, 25);
    send(a, 0); send(b, 0); send(c, 0); send(d, 1);
    exp_q = '{b};
    end_grp("R4 chi-square");
  endtask

  // R1: missing layers never shared (nmax=0 makes a single shared hit a duplicate)
  task automatic t_missing();
    trk_t a = mk(1, 1, 2, 3, 4, 3, 2, 10), b = mk(1, 1, 2, 3, 4, 12, 2, 10), c = mk(1, 1, 0, 0, 0, 1, 1, 1);
    nmax = 3'd0;
    send(a, 0); send(b, 0); send(c, 1);
    exp_q = '{a, b};
    end_grp("R1 missing layer");
    nmax = 3'd2;
  endtask

  // R5: road scope versus event scope
  task automatic t_mode();
    trk_t a = mk(1, 1, 2, 3, 4, 15, 4, 10), b = mk(2, 1, 2, 3, 4, 15, 4, 10);
    mode_all = 1'b0;
    send(a, 0); send(b, 1);
    exp_q = '{a, b};
    end_grp("R5 per-road");
    mode_all = 1'b1;
    send(a, 0); send(b, 1);
    exp_q = '{a};
    end_grp("R5 whole event");
    mode_all = 1'b0;
  endtask

  // R6: winner over two duplicates takes the first slot, the other leaves a hole
  task automatic t_multi();
    trk_t a = mk(1, 1, 2, 3, 9, 15, 4, 10), b = mk(1, 5, 6, 7, 8, 15, 4, 10), d = mk(1, 1, 2, 11, 12, 15, 4, 10);
    trk_t n = mk(1, 1, 2, 3, 12, 15, 4, 1), e = mk(1, 40, 41, 42, 43, 15, 4, 3);
    send(a, 0); send(b, 0); send(d, 0); send(n, 0); send(e, 1);
    exp_q = '{n, b, e};
    end_grp("R6 multi duplicate");
  endtask

  // R9: fifth distinct track passes straight through, flag sticky
  task automatic t_overflow();
    trk_t t[5];
    for (int i = 0; i < 5; i++) t[i] = mk(1, 10 * i + 1, 10 * i + 2, 10 * i + 3, 10 * i + 4, 15, 4, i);
    chk(ovf_err == 1'b0, "R9 flag clear before overflow", 64'(ovf_err), 64'd0);
    for (int i = 0; i < 5; i++) send(t[i], i == 4);
    chk(ovf_err == 1'b1, "R9 flag raised", 64'(ovf_err), 64'd1);
    exp_q = '{t[4], t[0], t[1], t[2], t[3]};
    end_grp("R9 pass-through");
    send(t[0], 1);
    exp_q = '{t[0]};
    end_grp("R9 later group");
    chk(ovf_err == 1'b1, "R9 flag sticky", 64'(ovf_err), 64'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    eog = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R10 reset in_ready", 64'(in_ready), 64'd1);
    chk(out_valid == 1'b0, "R10 reset out_valid", 64'(out_valid), 64'd0);
    chk(out_last == 1'b0, "R10 reset out_last", 64'(out_last), 64'd0);
    chk(ovf_err == 1'b0, "R10 reset ovf_err", 64'(ovf_err), 64'd0);
    t_order();
    t_thresh();
    t_hits();
    t_chi();
    t_missing();
    t_mode();
    t_multi();
    t_overflow();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule